// File: doc/BRIEF.md
# Digit-Serial GHASH Engine

This engine computes the authentication hash of Galois/Counter Mode over a sequence of 128-bit blocks. It keeps a running hash and a hash subkey. Each hash step folds one incoming block into the running value and multiplies the result by the subkey in GF(2^128). The multiplier is digit-serial: it takes a few bits of the subkey per clock cycle, so one product costs tens of cycles but needs only a small combinational array.

A sequencer drives the engine with four level start requests: load subkey, initialise, hash step and finalise. The engine acknowledges a request with a one-cycle pulse when it accepts it. It signals completion with a one-cycle done pulse. Operands enter and results leave through a 32-bit port into a four-word register bank, one word per cycle, most significant word first. The caller supplies the subkey, the padded data blocks and the length block.

Top module: `ghash_engine`

## Requirements
- R1: While reset is held, and on the first cycles after it, `ack`, `done`, `bankRdEn` and `bankWrEn` are all low.
- R2: A start request is accepted only when the engine is idle. `ack` rises on the cycle after an idle engine sees the request and lasts one cycle. A request raised while an operation is in progress stays unacknowledged until that operation's `done` has been given.
- R3: Load-subkey and hash-step read the bank over four consecutive cycles with `bankRdEn` high and `bankIdx` counting 0,1,2,3. Index 0 carries bits 127:96 of the block and index 3 carries bits 31:0. Load-subkey gives `done` four cycles after `ack`.
- R4: Initialise clears the running hash to zero and raises `done` in the same cycle as its `ack`.
- R5: A hash step replaces the hash Y with (Y XOR X) * H in GF(2^128), reduced by x^128 + x^7 + x^2 + x + 1. Bit 127 of a 128-bit word is the coefficient of x^0 and bit 0 is the coefficient of x^127, so the word 0x8000...0 is the field unit.
- R6: The multiplier takes 3 subkey bits per cycle, which gives 43 cycles per product. A hash step's `done` comes exactly 4 + 43 = 47 cycles after its `ack`.
- R7: Finalise writes the hash over four consecutive cycles with `bankWrEn` high and `bankIdx` counting 0..3, most significant word first. It gives `done` four cycles after `ack` and leaves the hash unchanged.
- R8: `done` is a one-cycle pulse. `bankRdEn` and `bankWrEn` are never high together.
- R9: When several requests are raised together, the engine accepts load-subkey first, then initialise, then hash step, then finalise. A request that loses stays pending.
- R10: Successive hash steps chain, so finalise returns the hash over the whole block sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| startLoadH | input | 1 | Request: read the subkey from the bank |
| startInit | input | 1 | Request: clear the running hash |
| startStep | input | 1 | Request: fold one block from the bank into the hash |
| startFinal | input | 1 | Request: write the hash to the bank |
| ack | output | 1 | One-cycle pulse: request accepted |
| done | output | 1 | One-cycle pulse: operation finished |
| bankRdEn | output | 1 | Bank read strobe |
| bankWrEn | output | 1 | Bank write strobe |
| bankIdx | output | 2 | Bank word index, 0 = most significant word |
| bankRdData | input | 32 | Word read from the bank |
| bankWrData | output | 32 | Word written to the bank |

## Verification
A wrong digit order, a bad reduction tap or a bit-reversal slip stays hidden inside the engine until the next finalise. It then shows up as a wrong hash word on `bankWrData`, so every hash step in the bench is followed by a finalise at some point. A sequencer that counts wrong shows up at once: `done` arrives off its fixed distance from `ack`, or `bankIdx` leaves its 0..3 order. A lost pending request shows up as an `ack` that never comes. An `ack` given while busy shows up before the earlier operation's `done`.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

  localparam int BLK_W = 128;

  typedef enum logic [2:0] {
    StIdle,
    StRead,
    StMul,
    StWrite,
    StFin
  } ghashStateE;

  typedef enum logic {
    OpKeyLoad,
    OpHashStep
  } ghashOpE;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capH;     // store the bank word into the subkey
    logic mixY;     // XOR the bank word into the hash
    logic clrY;     // zero the hash
    logic clrAcc;   // zero the product accumulator
    logic mulEn;    // advance the product by one digit
    logic commitY;  // move the finished product into the hash
  } dpCtrlT;

  // GCM word order to polynomial order: bit 127 of a word is x^0
  function automatic logic [BLK_W-1:0] revBits(input logic [BLK_W-1:0] v);
    logic [BLK_W-1:0] r;
    for (int i = 0; i < BLK_W; i++) r[i] = v[BLK_W-1-i];
    return r;
  endfunction

  // multiply by x and reduce by x^128 + x^7 + x^2 + x + 1
  function automatic logic [BLK_W-1:0] mulByX(input logic [BLK_W-1:0] v);
    logic [BLK_W-1:0] r;
    r = {v[BLK_W-2:0], 1'b0};
    if (v[BLK_W-1]) r = r ^ {{(BLK_W-8){1'b0}}, 8'h87};
    return r;
  endfunction

endpackage

// File: rtl/ghash_ctrl.sv
module ghash_ctrl
  import ghash_pkg::*;
#(
  parameter int NW = 4,
  parameter int ND = 43,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1,
  localparam int DW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startLoadH,
  input  logic          startInit,
  input  logic          startStep,
  input  logic          startFinal,
  output logic          ack,
  output logic          done,
  output logic          rdEn,
  output logic          wrEn,
  output logic [IW-1:0] wordIdx,
  output logic [DW-1:0] digitIdx,
  output dpCtrlT        ctl
);

  ghashStateE state, stateNxt;
  ghashOpE    op, opNxt;
  logic [IW-1:0] wordCnt;
  logic [DW-1:0] digitCnt;
  logic accept, lastWord, lastDigit;

  assign lastWord  = (wordCnt == IW'(NW - 1));
  assign lastDigit = (digitCnt == DW'(ND - 1));
  assign wordIdx   = wordCnt;
  assign digitIdx  = digitCnt;

  always_comb begin
    stateNxt = state;
    opNxt    = op;
    ctl      = '0;
    rdEn     = 1'b0;
    wrEn     = 1'b0;
    done     = 1'b0;
    accept   = 1'b0;
    unique case (state)
      StIdle: begin
        // fixed priority among simultaneous requests
        if (startLoadH) begin
          accept   = 1'b1;
          opNxt    = OpKeyLoad;
          stateNxt = StRead;
        end else if (startInit) begin
          accept   = 1'b1;
          ctl.clrY = 1'b1;
          stateNxt = StFin;
        end else if (startStep) begin
          accept   = 1'b1;
          opNxt    = OpHashStep;
          stateNxt = StRead;
        end else if (startFinal) begin
          accept   = 1'b1;
          stateNxt = StWrite;
        end
      end
      StRead: begin
        rdEn       = 1'b1;
        ctl.capH   = (op == OpKeyLoad);
        ctl.mixY   = (op == OpHashStep);
        ctl.clrAcc = 1'b1;
        if (lastWord) stateNxt = (op == OpHashStep) ? StMul : StFin;
      end
      StMul: begin
        ctl.mulEn = 1'b1;
        if (lastDigit) begin
          ctl.commitY = 1'b1;
          stateNxt    = StFin;
        end
      end
      StWrite: begin
        wrEn = 1'b1;
        if (lastWord) stateNxt = StFin;
      end
      StFin: begin
        done     = 1'b1;
        stateNxt = StIdle;
      end
      default: stateNxt = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= StIdle;
      op       <= OpKeyLoad;
      ack      <= 1'b0;
      wordCnt  <= '0;
      digitCnt <= '0;
    end else begin
      state <= stateNxt;
      op    <= opNxt;
      ack   <= accept;
      if ((rdEn || wrEn) && !lastWord) wordCnt <= wordCnt + 1'b1;
      else                             wordCnt <= '0;
      if (ctl.mulEn && !lastDigit) digitCnt <= digitCnt + 1'b1;
      else                         digitCnt <= '0;
    end
  end

endmodule

// File: rtl/ghash_dp.sv
module ghash_dp
  import ghash_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 3,
  localparam int NW   = BLK_W / WORD_W,
  localparam int ND   = (BLK_W + DIGIT_W - 1) / DIGIT_W,
  localparam int PADW = ND * DIGIT_W,
  localparam int IW   = (NW > 1) ? $clog2(NW) : 1,
  localparam int DW   = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrlT            ctl,
  input  logic [IW-1:0]     wordIdx,
  input  logic [DW-1:0]     digitIdx,
  input  logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] wrData
);

  logic [BLK_W-1:0] hReg, yReg, acc, accNext;
  logic [BLK_W-1:0] aPoly, partSum, shA, accSh;
  logic [PADW-1:0]  hPad;
  logic [DIGIT_W-1:0] digit;
  int digitPos, wordLo;

  always_comb begin
    // multiplicand: Y already holds Y xor X once the read phase ends
    aPoly              = revBits(yReg);
    hPad               = '0;
    hPad[BLK_W-1:0]    = revBits(hReg);
    // subkey digits taken most significant first (Horner order)
    digitPos = DIGIT_W * (ND - 1 - int'(digitIdx));
    digit    = hPad[digitPos +: DIGIT_W];
    partSum  = '0;
    shA      = aPoly;
    for (int b = 0; b < DIGIT_W; b++) begin
      if (digit[b]) partSum = partSum ^ shA;
      shA = mulByX(shA);
    end
    accSh = acc;
    for (int b = 0; b < DIGIT_W; b++) accSh = mulByX(accSh);
    accNext = accSh ^ partSum;
    wordLo  = (NW - 1 - int'(wordIdx)) * WORD_W;
    wrData  = yReg[wordLo +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hReg <= '0;
      yReg <= '0;
      acc  <= '0;
    end else begin
      if (ctl.capH) hReg[wordLo +: WORD_W] <= rdData;
      if (ctl.clrY)         yReg <= '0;
      else if (ctl.mixY)    yReg[wordLo +: WORD_W] <= yReg[wordLo +: WORD_W] ^ rdData;
      else if (ctl.commitY) yReg <= revBits(accNext);
      if (ctl.clrAcc)     acc <= '0;
      else if (ctl.mulEn) acc <= accNext;
    end
  end

endmodule

// File: rtl/ghash_engine.sv
module ghash_engine
  import ghash_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 3,
  localparam int NW = BLK_W / WORD_W,
  localparam int ND = (BLK_W + DIGIT_W - 1) / DIGIT_W,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1,
  localparam int DW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startLoadH,
  input  logic              startInit,
  input  logic              startStep,
  input  logic              startFinal,
  output logic              ack,
  output logic              done,
  output logic              bankRdEn,
  output logic              bankWrEn,
  output logic [IW-1:0]     bankIdx,
  input  logic [WORD_W-1:0] bankRdData,
  output logic [WORD_W-1:0] bankWrData
);

  dpCtrlT        ctl;
  logic [DW-1:0] digitIdx;

  ghash_ctrl #(.NW(NW), .ND(ND)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startLoadH (startLoadH),
    .startInit  (startInit),
    .startStep  (startStep),
    .startFinal (startFinal),
    .ack        (ack),
    .done       (done),
    .rdEn       (bankRdEn),
    .wrEn       (bankWrEn),
    .wordIdx    (bankIdx),
    .digitIdx   (digitIdx),
    .ctl        (ctl)
  );

  ghash_dp #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .wordIdx  (bankIdx),
    .digitIdx (digitIdx),
    .rdData   (bankRdData),
    .wrData   (bankWrData)
  );

endmodule

// File: rtl/ghash_engine_chk.sv
module ghash_engine_chk #(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 3,
  localparam int NW = 128 / WORD_W,
  localparam int ND = (128 + DIGIT_W - 1) / DIGIT_W,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          startLoadH,
  input logic          startInit,
  input logic          startStep,
  input logic          startFinal,
  input logic          ack,
  input logic          done,
  input logic          bankRdEn,
  input logic          bankWrEn,
  input logic [IW-1:0] bankIdx
);

  logic [3:0]  prevStart;  // {loadH, init, step, final} of the previous cycle
  logic        busyFlag, stepFlag;
  int unsigned sinceAck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevStart <= '0;
      busyFlag  <= 1'b0;
      stepFlag  <= 1'b0;
      sinceAck  <= 0;
    end else begin
      prevStart <= {startLoadH, startInit, startStep, startFinal};
      if (ack) begin
        busyFlag <= !done;
        stepFlag <= prevStart[1] && !prevStart[3] && !prevStart[2];
        sinceAck <= 1;
      end else begin
        if (done) busyFlag <= 1'b0;
        if (sinceAck < 100000) sinceAck <= sinceAck + 1;
      end
    end
  end

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (prevStart != 4'b0000));
  assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busyFlag);
  assert_rd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bankRdEn) |-> (bankIdx == '0));
  assert_rd_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bankRdEn && bankIdx != IW'(NW - 1)) |=> (bankRdEn && bankIdx == $past(bankIdx) + 1'b1));
  assert_step_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stepFlag && !ack) |-> (sinceAck == NW + ND));
  assert_wr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bankWrEn && bankIdx != IW'(NW - 1)) |=> (bankWrEn && bankIdx == $past(bankIdx) + 1'b1));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rw_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bankRdEn && bankWrEn));

endmodule

bind ghash_engine ghash_engine_chk #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startLoadH (startLoadH),
  .startInit  (startInit),
  .startStep  (startStep),
  .startFinal (startFinal),
  .ack        (ack),
  .done       (done),
  .bankRdEn   (bankRdEn),
  .bankWrEn   (bankWrEn),
  .bankIdx    (bankIdx)
);

// File: tb/tb_ghash_engine.sv
module tb_ghash_engine;

  localparam int K_LOADH = 0, K_INIT = 1, K_STEP = 2, K_FINAL = 3;
  localparam logic [127:0] GF_ONE = {1'b1, 127'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic startLoadH = 0, startInit = 0, startStep = 0, startFinal = 0;
  logic ack, done, bankRdEn, bankWrEn;
  logic [1:0]  bankIdx;
  logic [31:0] bankRdData, bankWrData;
  logic [31:0] bank [4];

  int checks = 0, errors = 0;
  logic [127:0] expQ [$];
  logic [127:0] refY = '0, refH = '0;
  int rdSeq = 0, wrSeq = 0;
  logic [127:0] wrBuf = '0;

  always #5ns clk = ~clk;

  assign bankRdData = bank[bankIdx];

  ghash_engine dut (
    .clk(clk), .rst_n(rst_n),
    .startLoadH(startLoadH), .startInit(startInit),
    .startStep(startStep), .startFinal(startFinal),
    .ack(ack), .done(done),
    .bankRdEn(bankRdEn), .bankWrEn(bankWrEn), .bankIdx(bankIdx),
    .bankRdData(bankRdData), .bankWrData(bankWrData)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference multiply in GCM bit order (right-shift form)
  function automatic logic [127:0] gfMul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z = '0, v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z ^= v;
      if (v[0]) v = (v >> 1) ^ {8'he1, 120'b0};
      else      v = v >> 1;
    end
    return z;
  endfunction

  task automatic putBlock(input logic [127:0] blk);
    for (int i = 0; i < 4; i++) bank[i] = blk[127-32*i -: 32];
  endtask

  task automatic setReq(input int kind, input logic val);
    case (kind)
      K_LOADH: startLoadH = val;
      K_INIT:  startInit  = val;
      K_STEP:  startStep  = val;
      default: startFinal = val;
    endcase
  endtask

  task automatic runCmd(input int kind, output int ackLat, output int doneLat);
    setReq(kind, 1'b1);
    ackLat = 0;
    do begin @(negedge clk); ackLat++; end while (!ack);
    setReq(kind, 1'b0);
    doneLat = 0;
    while (!done) begin @(negedge clk); doneLat++; end
  endtask

  // scoreboard monitor: bank port order and finalise results
  always @(negedge clk) begin
    if (rst_n) begin
      if (bankRdEn) begin
        chk(bankIdx == rdSeq[1:0], "R3 read index", 128'(bankIdx), 128'(rdSeq));
        rdSeq = (rdSeq + 1) % 4;
      end
      if (bankWrEn) begin
        chk(bankIdx == wrSeq[1:0], "R7 write index", 128'(bankIdx), 128'(wrSeq));
        wrBuf[127-32*wrSeq -: 32] = bankWrData;
        if (wrSeq == 3) begin
          if (expQ.size() == 0) chk(1'b0, "R7 unexpected finalise", wrBuf, '0);
          else begin
            logic [127:0] e;
            e = expQ.pop_front();
            chk(wrBuf == e, "R5/R10 hash value", wrBuf, e);
          end
        end
        wrSeq = (wrSeq + 1) % 4;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int al, dl;
    bit sawDone;
    logic [127:0] blocks [3];
    blocks[0] = 128'h0388dace60b6a392f328c2b971b2fe78;
    blocks[1] = 128'hfeedfacedeadbeeffeedfacedeadbeef;
    blocks[2] = 128'h00000000000000000000000000000080;
    putBlock('0);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ack && !done && !bankRdEn && !bankWrEn, "R1 outputs in reset", {ack, done, bankRdEn, bankWrEn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack && !done && !bankRdEn && !bankWrEn, "R1 outputs after reset", {ack, done, bankRdEn, bankWrEn}, 0);

    // R5: unit subkey leaves the block unchanged
    refH = GF_ONE; putBlock(refH);
    runCmd(K_LOADH, al, dl);
    chk(al == 1, "R2 ack latency", 128'(al), 1);
    chk(dl == 4, "R3 load done latency", 128'(dl), 4);
    runCmd(K_INIT, al, dl);
    chk(dl == 0, "R4 init done with ack", 128'(dl), 0);
    refY = '0;
    putBlock(blocks[1]);
    runCmd(K_STEP, al, dl);
    chk(dl == 47, "R6 step latency", 128'(dl), 47);
    refY = gfMul(refY ^ blocks[1], refH);
    chk(refY == blocks[1], "R5 model unit identity", refY, blocks[1]);
    expQ.push_back(blocks[1]);
    runCmd(K_FINAL, al, dl);
    chk(dl == 4, "R7 final done latency", 128'(dl), 4);

    // R4: init after a nonzero hash gives zero
    runCmd(K_INIT, al, dl);
    refY = '0;
    expQ.push_back('0);
    runCmd(K_FINAL, al, dl);

    // R10: three chained steps with a general subkey
    refH = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e; putBlock(refH);
    runCmd(K_LOADH, al, dl);
    runCmd(K_INIT, al, dl);
    refY = '0;
    for (int i = 0; i < 3; i++) begin
      putBlock(blocks[i]);
      runCmd(K_STEP, al, dl);
      chk(dl == 47, "R6 chained step latency", 128'(dl), 47);
      refY = gfMul(refY ^ blocks[i], refH);
    end
    expQ.push_back(refY);
    runCmd(K_FINAL, al, dl);
    expQ.push_back(refY);  // R7: finalise does not disturb the hash
    runCmd(K_FINAL, al, dl);

    // R2: final raised while a step is busy waits for done
    putBlock(128'h0123456789abcdef0f1e2d3c4b5a6978);
    startStep = 1'b1;
    do @(negedge clk); while (!ack);
    startStep = 1'b0;
    refY = gfMul(refY ^ 128'h0123456789abcdef0f1e2d3c4b5a6978, refH);
    expQ.push_back(refY);
    startFinal = 1'b1;
    sawDone = 1'b0;
    do begin
      @(negedge clk);
      if (ack && !sawDone) chk(1'b0, "R2 ack while busy", 1, 0);
      if (done) sawDone = 1'b1;
    end while (!ack);
    chk(sawDone, "R2 pending request acked after done", 128'(sawDone), 1);
    startFinal = 1'b0;
    while (!done) @(negedge clk);

    // R9: init and final together, init wins, final stays pending
    startInit = 1'b1; startFinal = 1'b1;
    do @(negedge clk); while (!ack);
    chk(done == 1'b1, "R9 init taken first", 128'(done), 1);
    startInit = 1'b0;
    refY = '0;
    expQ.push_back('0);
    do @(negedge clk); while (!ack);
    startFinal = 1'b0;
    dl = 0;
    while (!done) begin @(negedge clk); dl++; end
    chk(dl == 4, "R9 pending final served", 128'(dl), 4);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R7 all finalise results seen", 128'(expQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule